// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-port synchronous memory with a 64-bit data path split into eight 8-bit lanes. Its depth is set by a parameter. On each rising edge it registers the address, the write data, a chip select and the write controls. A write takes effect one edge later with no further handshake. A read goes through an output register, so its data appears after the edge that follows the edge that captured the address.

Writes are controlled at two levels. A global write strobe stores all eight lanes. Without it, eight per-lane strobes select individual lanes, but only while a lane-write enable is asserted. A cycle in which the chip is selected and no lane is written is a read. An asynchronous output enable only decides whether the read path drives. The bidirectional pads are modelled as a read bus plus a drive-valid flag, alongside a separate write bus. An external sequencer supplies every address.

Top module: `bsram_pipe`

## Requirements
- R1: While reset is applied and after it is released, with no access issued, `rvalid` is 0 and `rdata` is all zeros.
- R2: A read issued at edge k (chip selected, no lane written) sets `rvalid` to 1 and `rdata` to the stored word after edge k+1, provided `oe_n` is low.
- R3: When `gw_n` is low in a selected cycle, all eight lanes at the address are written, whatever `bwe_n` and `bw_n` are.
- R4: When `gw_n` is high and `bwe_n` is low, each lane i with `bw_n[i]` low is written from `wdata[8*i+7:8*i]`. Any number of lanes from one to eight may be written in one cycle.
- R5: When both `gw_n` and `bwe_n` are high, `bw_n` is ignored and the cycle is a read. The same applies when `bwe_n` is low but all `bw_n` bits are high.
- R6: A lane that is not written keeps its previous contents.
- R7: A read issued on the edge right after a write to the same address returns the newly written data.
- R8: `oe_n` acts without a clock edge. While it is high, `rvalid` is 0 and `rdata` is 0. Taking it low again restores the registered read word.
- R9: A cycle with `sel_n` high writes nothing, and `rvalid` is 0 after the following edge.
- R10: A write cycle does not drive the outputs. After edge k+1, `rvalid` is 0 and the output register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| sel_n | input | 1 | Active-low chip select, registered |
| addr | input | AW | Word address, registered |
| wdata | input | 64 | Write data, registered |
| gw_n | input | 1 | Active-low global write of all lanes |
| bwe_n | input | 1 | Active-low enable for the per-lane strobes |
| bw_n | input | 8 | Active-low per-lane write strobes, bit i covers wdata[8i+7:8i] |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 64 | Read data, zero while not driven |
| rvalid | output | 1 | High while the read path drives rdata |

## Verification
The bench sends a global write with the lane strobes deliberately idle. A design that honours the lane strobes over the global write would leave lanes stale. Sparse lane masks such as 0xA5 and single-lane writes expose a wrong lane-to-bit mapping or a clobbered neighbour lane. A cycle with the lane strobes asserted but their enable high must read back unchanged data: a design that ignores the enable would corrupt memory. A write issued under deselect, back-to-back write-then-read to one address, and an output-enable toggle in mid-cycle catch, respectively, a missing select qualification, an off-by-one pipeline and an output enable that was wrongly registered.

// File: rtl/bsram_pipe.sv
module bsram_pipe #(
  parameter int AW    = 6,
  parameter int LANES = 8,
  parameter int LW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic                  gw_n,
  input  logic                  bwe_n,
  input  logic [LANES-1:0]      bw_n,
  input  logic                  oe_n,
  output logic [LANES*LW-1:0]   rdata,
  output logic                  rvalid
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0]    a_q;
  logic [DW-1:0]    d_q;
  logic [LANES-1:0] m_q;
  logic             s_q;
  logic             rd_q;
  logic [DW-1:0]    q_r;
  logic [DW-1:0]    rd_word;
  logic [LANES-1:0] lane_mask;

  assign lane_mask = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      m_q <= '0;
      a_q <= '0;
      d_q <= '0;
    end else begin
      s_q <= !sel_n;
      m_q <= lane_mask;
      a_q <= addr;
      d_q <= wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (s_q && m_q[g]) mem[a_q] <= d_q[g*LW +: LW];
    end
    assign rd_word[g*LW +: LW] = mem[a_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      q_r  <= '0;
    end else begin
      rd_q <= s_q && (m_q == '0);
      if (s_q && (m_q == '0)) q_r <= rd_word;
    end
  end

  assign rvalid = rd_q && !oe_n;
  assign rdata  = rvalid ? q_r : '0;

  // R9
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> ##2 !rd_q);

  // R2
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && gw_n && (bwe_n || (&bw_n))) |-> ##2 rd_q);

  // R5
  lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && gw_n && bwe_n && !(&bw_n)) |-> ##2 rd_q);

  // R10
  wr_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !gw_n) |-> ##2 !rd_q);

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !gw_n) |-> ##2 $stable(q_r));
endmodule

// File: tb/sim_bsram_pipe.sv
module sim_bsram_pipe;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0, sel_n = 1, gw_n = 1, bwe_n = 1, oe_n = 0;
  logic [AW-1:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic [7:0] bw_n = '1;
  logic rvalid;
  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] model [64];

  typedef struct { bit v; logic [63:0] d; int due; string req; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bsram_pipe #(.AW(AW)) u0 (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .addr(addr),
    .wdata(wdata), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid));

  task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit sel, input bit gw, input bit bwe, input logic [7:0] bw,
                    input logic [AW-1:0] a, input logic [63:0] d, input string req);
    logic [7:0] m;
    exp_t e;
    @(negedge clk);
    sel_n = !sel; gw_n = gw; bwe_n = bwe; bw_n = bw; addr = a; wdata = d;
    m = !gw ? 8'hFF : (!bwe ? ~bw : 8'h00);
    e.due = cyc + 2; e.req = req; e.v = 0; e.d = '0;
    if (sel) begin
      if (m != 0) begin
        for (int i = 0; i < 8; i++) if (m[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
      end else begin
        e.v = 1; e.d = model[a];
      end
    end
    sb.push_back(e);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    op(1, 1, 1, 8'hFF, a, 64'h0, req);
  endtask

  task automatic idle(input string req);
    op(0, 1, 1, 8'hFF, '0, 64'h0, req);
  endtask

  always @(posedge clk) begin
    #15;
    while (sb.size() != 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(rvalid == e.v && rdata == e.d, e.req, {rvalid, rdata}, {e.v, e.d});
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 chk(rvalid == 0 && rdata == 0, "R1 in reset", {rvalid, rdata}, 65'h0);
    @(negedge clk) rst_n = 1;
    repeat (2) @(posedge clk);
    #5 chk(rvalid == 0 && rdata == 0, "R1 after reset", {rvalid, rdata}, 65'h0);

    for (int a = 0; a < 64; a++)
      op(1, 0, 0, 8'h00, a[AW-1:0], {2{a[7:0] ^ 8'h3C, 24'h5A5A5A}} + 64'(a), "R10 fill");
    // R3: global write overrides idle lane strobes
    op(1, 0, 1, 8'hFF, 6'd0, 64'h0123_4567_89AB_CDEF, "R10 gw");
    rd(6'd0, "R3 gw all lanes");
    // R4 / R6: sparse lanes
    op(1, 0, 1, 8'hFF, 6'd1, 64'h1111_1111_1111_1111, "R10 gw");
    op(1, 1, 0, ~8'hA5, 6'd1, 64'hFFEE_DDCC_BBAA_9988, "R10 bw");
    rd(6'd1, "R4 R6 sparse lanes");
    // R5: strobes without enable are ignored
    op(1, 1, 1, 8'h00, 6'd1, 64'hDEAD_BEEF_DEAD_BEEF, "R5 ignored strobes");
    op(1, 1, 0, 8'hFF, 6'd1, 64'hDEAD_BEEF_DEAD_BEEF, "R5 no lane");
    rd(6'd1, "R5 R6 unchanged");
    // R4 single lanes, R7 back-to-back
    for (int i = 0; i < 8; i++) begin
      op(1, 1, 0, ~(8'h01 << i), 6'd2, {8{8'(8'h10 + i)}}, "R10 lane");
      rd(6'd2, "R4 R7 single lane");
    end
    op(1, 1, 0, 8'h00, 6'd3, 64'hCAFE_F00D_1234_5678, "R10 all bw");
    rd(6'd3, "R4 R7 eight lanes");
    // R9: deselected write does nothing
    op(0, 0, 0, 8'h00, 6'd4, 64'hBAD0_BAD0_BAD0_BAD0, "R9 desel");
    rd(6'd4, "R9 no write");
    // R2: burst of reads
    for (int a = 10; a < 16; a++) rd(a[AW-1:0], "R2 read stream");
    // R8: asynchronous output enable
    rd(6'd0, "R8 pre");
    idle("R9 idle");
    @(posedge clk); #3;
    chk(rvalid && rdata == 64'h0123_4567_89AB_CDEF, "R8 driven", {rvalid, rdata}, {1'b1, 64'h0123_4567_89AB_CDEF});
    oe_n = 1; #1;
    chk(!rvalid && rdata == 0, "R8 oe high", {rvalid, rdata}, 65'h0);
    oe_n = 0; #1;
    chk(rvalid && rdata == 64'h0123_4567_89AB_CDEF, "R8 restored", {rvalid, rdata}, {1'b1, 64'h0123_4567_89AB_CDEF});
    for (int k = 0; k < 4; k++) idle("R9 idle");
    repeat (4) @(posedge clk);
    #17;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule